// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block generates data-memory addresses for a signal-processing datapath. It keeps a small set of pointer contexts. Each context has four registers: a current pointer, a ring base, a ring limit and a stride. Software loads these registers through a configuration write port. On each cycle the datapath selects one context and one access mode. The block then presents an address at once. When the step strobe is high, the selected pointer is advanced on the next clock edge.

Five modes are provided:

- plain indirect;
- indexed by an external offset;
- post-increment;
- pre-decrement;
- ring stepping.

Ring stepping serves delay lines and coefficient tables in FIR loops. After an access, a pointer that sits exactly on the ring limit jumps back to the ring base. Any other pointer moves forward by the stride. Outside ring stepping, all pointer arithmetic wraps modulo 2^AW.

Top module: `circ_agu`

## Requirements
- R1: While reset is asserted and after its release, every pointer, base, limit and stride register reads zero, so `mem_addr` is 0 in mode 0 for every context.
- R2: Mode 0 (indirect) drives `mem_addr` with the selected pointer, and a step strobe leaves that pointer unchanged.
- R3: Mode 1 (indexed) drives `mem_addr` with pointer + `index_off` modulo 2^AW, and a step strobe leaves the pointer unchanged.
- R4: Mode 2 (post-increment) drives `mem_addr` with the pointer. On a step strobe the pointer becomes pointer + 1 modulo 2^AW.
- R5: Mode 3 (pre-decrement) drives `mem_addr` with pointer − 1 modulo 2^AW. On a step strobe the pointer takes that same value.
- R6: Mode 4 (ring) drives `mem_addr` with the pointer. On a step strobe, a pointer equal to the limit becomes the base. Otherwise it becomes pointer + stride modulo 2^AW, so a pointer that steps past the limit without equalling it does not wrap.
- R7: Without a step strobe or a pointer write, a pointer holds its value in every mode.
- R8: A configuration write to field 0 (pointer) of the context being stepped in the same cycle wins: the written value is loaded and the step is discarded.
- R9: Steps and writes change only the addressed context. Field codes: 0 pointer, 1 base, 2 limit, 3 stride. `cfg_ptr` and `ptr_sel` pick the context.
- R10: Writes to fields 1, 2 and 3 never change the pointer. A ring step in the same cycle uses the base, limit and stride values from before the write.
- R11: Mode codes 5, 6 and 7 behave as mode 0: the address is the pointer and the pointer is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write enable |
| cfg_field | input | 2 | Register field written: 0 pointer, 1 base, 2 limit, 3 stride |
| cfg_ptr | input | PW | Context that the write targets |
| cfg_data | input | AW | Write data |
| step_en | input | 1 | Advance the selected pointer at the clock edge |
| ptr_sel | input | PW | Context used for the access |
| acc_mode | input | 3 | Access mode code |
| index_off | input | AW | Offset for indexed mode |
| mem_addr | output | AW | Generated address |

## Verification
`mem_addr` is combinational, so the address for a cycle is due in that cycle. It is set by the inputs driven at the falling edge and the register state after the previous rising edge. The effect of a step or a write appears as the address of the following cycle, one rising edge later.

The driver computes both values from a reference model of the requirements and queues the expected address. The monitor compares the queued address a few nanoseconds after the same falling edge, well away from the rising edge that updates state. Each update is therefore observed exactly one cycle after its stimulus.

// File: rtl/circ_agu_pkg.sv
package circ_agu_pkg;

  // access mode codes seen on acc_mode
  typedef enum logic [2:0] {
    MD_INDIRECT = 3'd0,
    MD_INDEXED  = 3'd1,
    MD_POSTINC  = 3'd2,
    MD_PREDEC   = 3'd3,
    MD_RING     = 3'd4
  } acc_mode_e;

  // configuration field codes seen on cfg_field
  typedef enum logic [1:0] {
    FLD_PTR    = 2'd0,
    FLD_BASE   = 2'd1,
    FLD_LIMIT  = 2'd2,
    FLD_STRIDE = 2'd3
  } cfg_field_e;

endpackage

// File: rtl/circ_agu_step.sv
// Combinational address and next-pointer computation for one context.
module circ_agu_step
  import circ_agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [2:0]    mode,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  input  logic [AW-1:0] stride,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] nxt_ptr
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] dec_val;
  logic          at_limit;

  assign dec_val  = cur - ONE;
  assign at_limit = (cur == limit);

  always_comb begin
    eff_addr = cur;
    nxt_ptr  = cur;
    case (mode)
      MD_INDEXED: begin
        eff_addr = cur + offset;
      end
      MD_POSTINC: begin
        nxt_ptr = cur + ONE;
      end
      MD_PREDEC: begin
        eff_addr = dec_val;
        nxt_ptr  = dec_val;
      end
      MD_RING: begin
        nxt_ptr = at_limit ? base : (cur + stride);
      end
      default: begin
        eff_addr = cur;
        nxt_ptr  = cur;
      end
    endcase
  end

endmodule

// File: rtl/circ_agu_ctx.sv
// One pointer context: pointer, ring base, ring limit and stride registers.
module circ_agu_ctx
  import circ_agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_field,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_val,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] limit_q,
  output logic [AW-1:0] stride_q
);

  logic          ptr_wr, base_wr, limit_wr, stride_wr;
  logic          ptr_ce;
  logic [AW-1:0] ptr_d, base_d, limit_d, stride_d;

  assign ptr_wr    = wr_en && (wr_field == FLD_PTR);
  assign base_wr   = wr_en && (wr_field == FLD_BASE);
  assign limit_wr  = wr_en && (wr_field == FLD_LIMIT);
  assign stride_wr = wr_en && (wr_field == FLD_STRIDE);
  assign ptr_ce    = ptr_wr || upd_en;

  // next-state: a software write outranks the step
  always_comb begin
    ptr_d    = ptr_q;
    base_d   = base_q;
    limit_d  = limit_q;
    stride_d = stride_q;
    if (ptr_wr)         ptr_d = wr_data;
    else if (upd_en)    ptr_d = upd_val;
    if (base_wr)        base_d = wr_data;
    if (limit_wr)       limit_d = wr_data;
    if (stride_wr)      stride_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_ce) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_wr) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
    end else if (limit_wr) begin
      limit_q <= limit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stride_q <= '0;
    end else if (stride_wr) begin
      stride_q <= stride_d;
    end
  end

  // R8: a pointer write is loaded even when a step arrives with it
  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (ptr_q == $past(wr_data)));

  // R7: no write and no step keeps the pointer
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !upd_en) |=> $stable(ptr_q));

  // R10: config fields other than the pointer leave the ring set otherwise stable
  p_cfg_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(base_q) && $stable(limit_q) && $stable(stride_q)));

endmodule

// File: rtl/circ_agu.sv
module circ_agu
  import circ_agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NPTR = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_we,
  input  logic [1:0]                            cfg_field,
  input  logic [((NPTR > 1) ? $clog2(NPTR) : 1)-1:0] cfg_ptr,
  input  logic [AW-1:0]                         cfg_data,
  input  logic                                  step_en,
  input  logic [((NPTR > 1) ? $clog2(NPTR) : 1)-1:0] ptr_sel,
  input  logic [2:0]                            acc_mode,
  input  logic [AW-1:0]                         index_off,
  output logic [AW-1:0]                         mem_addr
);

  localparam int PW = (NPTR > 1) ? $clog2(NPTR) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  logic [AW-1:0] ptr_a    [NPTR];
  logic [AW-1:0] base_a   [NPTR];
  logic [AW-1:0] limit_a  [NPTR];
  logic [AW-1:0] stride_a [NPTR];

  logic [AW-1:0] sel_ptr, sel_base, sel_limit, sel_stride;
  logic [AW-1:0] nxt_ptr;

  always_comb begin
    sel_ptr    = '0;
    sel_base   = '0;
    sel_limit  = '0;
    sel_stride = '0;
    for (int k = 0; k < NPTR; k++) begin
      if (ptr_sel == PW'(k)) begin
        sel_ptr    = ptr_a[k];
        sel_base   = base_a[k];
        sel_limit  = limit_a[k];
        sel_stride = stride_a[k];
      end
    end
  end

  circ_agu_step #(.AW(AW)) u_step (
    .mode     (acc_mode),
    .cur      (sel_ptr),
    .base     (sel_base),
    .limit    (sel_limit),
    .stride   (sel_stride),
    .offset   (index_off),
    .eff_addr (mem_addr),
    .nxt_ptr  (nxt_ptr)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ctx
    logic wr_hit, upd_hit;
    assign wr_hit  = cfg_we  && (cfg_ptr == PW'(g));
    assign upd_hit = step_en && (ptr_sel == PW'(g));

    circ_agu_ctx #(.AW(AW)) u_ctx (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .wr_en    (wr_hit),
      .wr_field (cfg_field),
      .wr_data  (cfg_data),
      .upd_en   (upd_hit),
      .upd_val  (nxt_ptr),
      .ptr_q    (ptr_a[g]),
      .base_q   (base_a[g]),
      .limit_q  (limit_a[g]),
      .stride_q (stride_a[g])
    );
  end

  // step on the selected context without a competing pointer write
  logic clean_step;
  assign clean_step = step_en &&
                      !(cfg_we && (cfg_field == FLD_PTR) && (cfg_ptr == ptr_sel));

  // R4: post-increment advances by one
  p_postinc_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (clean_step && acc_mode == MD_POSTINC) |=>
      (ptr_a[$past(ptr_sel)] == $past(sel_ptr) + AW'(1)));

  // R5: pre-decrement stores the address it presented
  p_predec_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (clean_step && acc_mode == MD_PREDEC) |=>
      (ptr_a[$past(ptr_sel)] == $past(mem_addr)));

  // R6: a pointer on the limit reloads the base
  p_ring_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (clean_step && acc_mode == MD_RING && sel_ptr == sel_limit) |=>
      (ptr_a[$past(ptr_sel)] == $past(sel_base)));

  // R2 / R3 / R11: non-moving modes keep the pointer
  p_static_modes_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (clean_step && (acc_mode == MD_INDIRECT || acc_mode == MD_INDEXED ||
                    acc_mode > MD_RING)) |=> $stable(ptr_a[$past(ptr_sel)]));

endmodule

// File: tb/circ_agu_bench.sv
module circ_agu_bench;

  localparam int AW = 16;
  localparam int NPTR = 2;
  localparam int PW = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_field;
  logic [PW-1:0] cfg_ptr;
  logic [AW-1:0] cfg_data;
  logic          step_en;
  logic [PW-1:0] ptr_sel;
  logic [2:0]    acc_mode;
  logic [AW-1:0] index_off;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  circ_agu #(.AW(AW), .NPTR(NPTR)) u_circ_agu (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
    .cfg_ptr(cfg_ptr), .cfg_data(cfg_data), .step_en(step_en),
    .ptr_sel(ptr_sel), .acc_mode(acc_mode), .index_off(index_off),
    .mem_addr(mem_addr)
  );

  // reference model state
  logic [AW-1:0] m_ptr [NPTR];
  logic [AW-1:0] m_bas [NPTR];
  logic [AW-1:0] m_lim [NPTR];
  logic [AW-1:0] m_str [NPTR];

  logic [AW-1:0] exp_q [$];
  string         tag_q [$];
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 0;

  task automatic report_and_end();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // driver: drives one cycle, queues the expected address, advances the model
  task automatic cyc(input bit we, input int fld, input int cp, input int dat,
                     input bit upd, input int ps, input int md, input int off,
                     input string tag);
    logic [AW-1:0] a, e, n;
    @(negedge clk);
    cfg_we = we; cfg_field = 2'(fld); cfg_ptr = PW'(cp); cfg_data = AW'(dat);
    step_en = upd; ptr_sel = PW'(ps); acc_mode = 3'(md); index_off = AW'(off);
    a = m_ptr[ps];
    case (md)
      1: e = a + AW'(off);
      3: e = a - 1'b1;
      default: e = a;
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
    n = a;
    if (upd) begin
      case (md)
        2: n = a + 1'b1;
        3: n = a - 1'b1;
        4: n = (a == m_lim[ps]) ? m_bas[ps] : a + m_str[ps];
        default: n = a;
      endcase
      m_ptr[ps] = n;
    end
    if (we) begin
      case (fld)
        0: m_ptr[cp] = AW'(dat);
        1: m_bas[cp] = AW'(dat);
        2: m_lim[cp] = AW'(dat);
        default: m_str[cp] = AW'(dat);
      endcase
    end
  endtask

  task automatic wr(input int cp, input int fld, input int dat, input string tag);
    cyc(1, fld, cp, dat, 0, cp, 0, 0, tag);
  endtask

  // monitor: compares queued expectations away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      while (exp_q.size() > 0) begin
        logic [AW-1:0] ev;
        string t;
        ev = exp_q.pop_front();
        t  = tag_q.pop_front();
        n_chk++;
        if (mem_addr !== ev) begin
          n_fail++;
          $display("FAIL %s: mem_addr actual %h expected %h", t, mem_addr, ev);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report_and_end();
    end
  end

  initial begin
    for (int i = 0; i < NPTR; i++) begin
      m_ptr[i] = '0; m_bas[i] = '0; m_lim[i] = '0; m_str[i] = '0;
    end
    rst_n = 1'b0;
    cfg_we = 0; cfg_field = 0; cfg_ptr = 0; cfg_data = 0;
    step_en = 0; ptr_sel = 0; acc_mode = 0; index_off = 0;
    repeat (3) @(negedge clk);
    // R1: address during reset
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R1");

    // ring set for context 0
    wr(0, 0, 'h0100, "R9");
    wr(0, 1, 'h0100, "R10");
    wr(0, 2, 'h0103, "R10");
    wr(0, 3, 1, "R10");
    // R2: indirect with step
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R3: indexed, plus wrap-around offset
    cyc(0, 0, 0, 0, 1, 0, 1, 'h0020, "R3");
    cyc(0, 0, 0, 0, 1, 0, 1, 'hFFFF, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R6: ring walk past the limit back to base
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, 0, 4, 0, "R6");
    // R6: stride 2 overshoots the limit without wrapping
    wr(0, 0, 'h0010, "R6");
    wr(0, 1, 'h0010, "R6");
    wr(0, 2, 'h0015, "R6");
    wr(0, 3, 2, "R6");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 0, 4, 0, "R6");
    // R4: post-increment wraps at the top of the space
    wr(0, 0, 'hFFFE, "R4");
    cyc(0, 0, 0, 0, 1, 0, 2, 0, "R4");
    cyc(0, 0, 0, 0, 1, 0, 2, 0, "R4");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R4");
    // R5: pre-decrement from zero
    wr(0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 1, 0, 3, 0, "R5");
    cyc(0, 0, 0, 0, 1, 0, 3, 0, "R5");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R7: moving modes without a strobe
    cyc(0, 0, 0, 0, 0, 0, 2, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 4, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 3, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R7");
    // R8: write and step on the same context
    cyc(1, 0, 0, 'h0AB0, 1, 0, 2, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R8");
    // R9: context 1 works alone, context 0 untouched
    wr(1, 0, 'h2000, "R9");
    cyc(0, 0, 0, 0, 1, 1, 2, 0, "R9");
    cyc(1, 0, 1, 'h3000, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R10: limit write in same cycle as ring step uses old limit
    wr(0, 0, 'h0050, "R10");
    wr(0, 1, 'h0040, "R10");
    wr(0, 2, 'h0050, "R10");
    wr(0, 3, 4, "R10");
    cyc(1, 2, 0, 'h0060, 1, 0, 4, 0, "R10");
    cyc(1, 3, 0, 7, 1, 0, 4, 0, "R10");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    // R11: reserved mode codes
    for (int m = 5; m < 8; m++) cyc(0, 0, 0, 0, 1, 0, m, 'h0101, "R11");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R11");

    repeat (2) @(negedge clk);
    #6;
    done = 1;
    report_and_end();
  end

endmodule